// File: doc/BRIEF.md
# Patchable Microcode Sequencer

This sequencer steps through microinstructions held in a fixed read-only store. Execution can be steered into a small writable patch store without touching that fixed content. A bank of match registers watches every address fetched from the read-only store. When an armed and enabled register matches, the sequencer spends one bubble cycle and then continues from the patch entry point named in that register. Patch code is ordinary microcode. Its next-address field can name either address space, so a patch can replace a stretch of the fixed flow and then jump back to any address in it.

Software fills the patch store and the match registers through a single address/data/write-enable port. A match register can be armed only once its target patch word has been written. A separate per-register enable input lets the surrounding logic mask individual registers. An entry request from instruction decode sets the next fetch address in the read-only store. With no register armed, the block runs purely from the read-only store.

Top module: `ucode_seq`

## Requirements
- R1: After reset, the fetch address is 0 in the read-only space. All match registers are disarmed and every patch word is marked unwritten. A register armed after reset with a target that has not been rewritten stays disarmed, and no fetch traps.
- R2: A microinstruction is 32 bits wide. Bit 31 is the jump flag and bit 30 is the target space (0 = read-only store, 1 = patch store). Bits 29:18 hold the target address and bits 17:0 the payload. The read-only word at address a has jump=0 and space=0, so it equals a zero-extended to 32 bits. A non-jump word in the read-only space is followed by address a+1.
- R3: When disp_valid_i is high, the next fetch is disp_addr_i in the read-only space. This overrides a jump, a sequential step and a pending trap.
- R4: A read-only fetch whose address equals an armed, enabled match register shows uop_valid_o=0 and uop_o=0 in that cycle. The following cycle fetches the register's patch target.
- R5: When several armed, enabled registers match, the lowest-numbered one selects the patch target.
- R6: A fetch from the patch space never traps, even if its address equals a register's address.
- R7: In the patch space, a non-jump word at index 59 is followed by index 0, and any other non-jump word by index+1. A jump word goes to the target in the space its space bit names; for the patch space only target bits 5:0 are used.
- R8: Bit k of match_en_i low masks register k. With all enable bits low, every read-only fetch is valid.
- R9: A match register write with the valid bit set arms the register only if its target patch word has been written since reset. Otherwise it is stored disarmed. A write with the valid bit clear disarms the register.
- R10: cfg_addr_i[6]=0 writes patch word cfg_addr_i[5:0] with cfg_wdata_i; indices 60 and above are ignored and never count as written. cfg_addr_i[6]=1 writes match register cfg_addr_i[1:0] with valid=cfg_wdata_i[18], address=cfg_wdata_i[17:6] and target=cfg_wdata_i[5:0]. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Entry request from instruction decode |
| disp_addr_i | input | 12 | Entry address in the read-only space |
| match_en_i | input | 4 | Per-register match enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Configuration address: bit 6 picks the match bank |
| cfg_wdata_i | input | 32 | Configuration write data |
| uop_valid_o | output | 1 | Low during a trap bubble |
| uop_o | output | 32 | Microinstruction fetched this cycle |
| upc_space_o | output | 1 | Space of the current fetch (1 = patch) |
| upc_addr_o | output | 12 | Address of the current fetch |

## Verification
The redirect logic is exercised with straight runs of read-only fetches, single and overlapping matches at one address, and a match whose target word was never written. Together these separate a correct trap from a missed one, a wrong priority and a skipped arming check. Further runs mask one register so the next-lower-priority register takes over, fetch a patch word whose index equals an armed address, and wrap around the top of the patch store. An entry request during a trap cycle confirms that the request wins. A disarm write, an out-of-range patch target and a second reset show that the arming state and the written-word record really clear.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    // Address space of a microcode fetch
    typedef enum logic {
        SPC_ROM   = 1'b0,
        SPC_PATCH = 1'b1
    } space_e;

endpackage

// File: rtl/ucode_rom.sv
// Fixed microcode store: each word carries its own address as payload
// and continues sequentially.
module ucode_rom #(
    parameter int UW  = 32,
    parameter int RAW = 12
) (
    input  logic [RAW-1:0] addr_i,
    output logic [UW-1:0]  word_o
);
    localparam int PLW = UW - 2 - RAW;

    always_comb begin
        word_o = {2'b00, {RAW{1'b0}}, PLW'(addr_i)};
    end
endmodule

// File: rtl/ucode_patch_store.sv
// Writable patch words plus a per-word "written since reset" record.
module ucode_patch_store #(
    parameter int UW    = 32,
    parameter int PAW   = 6,
    parameter int DEPTH = 60
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           wr_en_i,
    input  logic [PAW-1:0] wr_idx_i,
    input  logic [UW-1:0]  wr_data_i,
    input  logic [PAW-1:0] rd_idx_i,
    output logic [UW-1:0]  rd_data_o,
    input  logic [PAW-1:0] chk_idx_i,
    output logic           chk_written_o
);
    typedef struct packed {
        logic [DEPTH-1:0][UW-1:0] mem;
        logic [DEPTH-1:0]         done;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (int'(wr_idx_i) < DEPTH)) begin
            st_d.mem[wr_idx_i]  = wr_data_i;
            st_d.done[wr_idx_i] = 1'b1;
        end
        rd_data_o     = (int'(rd_idx_i) < DEPTH) ? st_q.mem[rd_idx_i] : '0;
        chk_written_o = (int'(chk_idx_i) < DEPTH) ? st_q.done[chk_idx_i] : 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ucode_match_bank.sv
// Match registers: address compare against read-only fetches with
// lowest-index priority and an arming check on write.
module ucode_match_bank #(
    parameter int RAW    = 12,
    parameter int PAW    = 6,
    parameter int NMATCH = 4,
    localparam int IW    = (NMATCH > 1) ? $clog2(NMATCH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic              wr_valid_i,
    input  logic [RAW-1:0]    wr_rom_i,
    input  logic [PAW-1:0]    wr_tgt_i,
    input  logic              tgt_ok_i,
    input  logic [NMATCH-1:0] en_i,
    input  logic              look_en_i,
    input  logic [RAW-1:0]    look_addr_i,
    output logic              hit_o,
    output logic [PAW-1:0]    tgt_o
);
    typedef struct packed {
        logic [NMATCH-1:0]          vld;
        logic [NMATCH-1:0][RAW-1:0] rom;
        logic [NMATCH-1:0][PAW-1:0] tgt;
    } mst_t;

    mst_t st_d, st_q;
    logic [NMATCH-1:0] cmp;
    logic [IW-1:0]     win;
    logic              any;

    genvar g;
    generate
        for (g = 0; g < NMATCH; g++) begin : g_cmp
            assign cmp[g] = st_q.vld[g] & en_i[g] & (st_q.rom[g] == look_addr_i);
        end
    endgenerate

    always_comb begin
        win = '0;
        any = 1'b0;
        for (int k = NMATCH - 1; k >= 0; k--) begin
            if (cmp[k]) begin
                any = 1'b1;
                win = IW'(k);
            end
        end
        hit_o = look_en_i & any;
        tgt_o = st_q.tgt[win];
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i && (int'(wr_idx_i) < NMATCH)) begin
            st_d.vld[wr_idx_i] = wr_valid_i & tgt_ok_i;
            st_d.rom[wr_idx_i] = wr_rom_i;
            st_d.tgt[wr_idx_i] = wr_tgt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ucode_seq.sv
// Microcode sequencer with match-trap redirection into a patch store.
module ucode_seq
    import ucode_pkg::*;
#(
    parameter int UW     = 32,
    parameter int RAW    = 12,
    parameter int PAW    = 6,
    parameter int DEPTH  = 60,
    parameter int NMATCH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              disp_valid_i,
    input  logic [RAW-1:0]    disp_addr_i,
    input  logic [NMATCH-1:0] match_en_i,
    input  logic              cfg_we_i,
    input  logic [PAW:0]      cfg_addr_i,
    input  logic [UW-1:0]     cfg_wdata_i,
    output logic              uop_valid_o,
    output logic [UW-1:0]     uop_o,
    output logic              upc_space_o,
    output logic [RAW-1:0]    upc_addr_o
);
    localparam int IW      = (NMATCH > 1) ? $clog2(NMATCH) : 1;
    localparam int JMP_BIT = UW - 1;
    localparam int SPC_BIT = UW - 2;
    localparam int MV_BIT  = RAW + PAW;

    typedef struct packed {
        space_e         spc;
        logic [RAW-1:0] addr;
    } upc_t;

    upc_t st_d, st_q;

    logic [UW-1:0]  rom_word;
    logic [UW-1:0]  patch_word;
    logic [UW-1:0]  fetch_word;
    logic           tgt_ok;
    logic           hit;
    logic [PAW-1:0] hit_tgt;
    logic           trap;
    logic           in_rom;
    logic [PAW-1:0] pc_low;
    logic [PAW-1:0] pc_low_inc;

    assign in_rom = (st_q.spc == SPC_ROM);
    assign pc_low = st_q.addr[PAW-1:0];

    ucode_rom #(.UW(UW), .RAW(RAW)) u_rom (
        .addr_i (st_q.addr),
        .word_o (rom_word)
    );

    ucode_patch_store #(.UW(UW), .PAW(PAW), .DEPTH(DEPTH)) u_patch (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (cfg_we_i & ~cfg_addr_i[PAW]),
        .wr_idx_i      (cfg_addr_i[PAW-1:0]),
        .wr_data_i     (cfg_wdata_i),
        .rd_idx_i      (pc_low),
        .rd_data_o     (patch_word),
        .chk_idx_i     (cfg_wdata_i[PAW-1:0]),
        .chk_written_o (tgt_ok)
    );

    ucode_match_bank #(.RAW(RAW), .PAW(PAW), .NMATCH(NMATCH)) u_match (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (cfg_we_i & cfg_addr_i[PAW]),
        .wr_idx_i    (cfg_addr_i[IW-1:0]),
        .wr_valid_i  (cfg_wdata_i[MV_BIT]),
        .wr_rom_i    (cfg_wdata_i[MV_BIT-1:PAW]),
        .wr_tgt_i    (cfg_wdata_i[PAW-1:0]),
        .tgt_ok_i    (tgt_ok),
        .en_i        (match_en_i),
        .look_en_i   (in_rom),
        .look_addr_i (st_q.addr),
        .hit_o       (hit),
        .tgt_o       (hit_tgt)
    );

    always_comb begin
        fetch_word = in_rom ? rom_word : patch_word;
        trap       = in_rom & hit;
        pc_low_inc = (pc_low >= PAW'(DEPTH - 1)) ? '0 : pc_low + 1'b1;

        // default: sequential step in the current space
        st_d = st_q;
        if (in_rom) begin
            st_d.addr = st_q.addr + 1'b1;
        end else begin
            st_d.addr = {{(RAW-PAW){1'b0}}, pc_low_inc};
        end

        if (fetch_word[JMP_BIT]) begin
            st_d.spc = space_e'(fetch_word[SPC_BIT]);
            if (fetch_word[SPC_BIT]) begin
                st_d.addr = {{(RAW-PAW){1'b0}}, fetch_word[SPC_BIT-RAW +: PAW]};
            end else begin
                st_d.addr = fetch_word[SPC_BIT-1 -: RAW];
            end
        end

        if (trap) begin
            st_d.spc  = SPC_PATCH;
            st_d.addr = {{(RAW-PAW){1'b0}}, hit_tgt};
        end

        if (disp_valid_i) begin
            st_d.spc  = SPC_ROM;
            st_d.addr = disp_addr_i;
        end

        uop_valid_o = ~trap;
        uop_o       = trap ? '0 : fetch_word;
        upc_space_o = st_q.spc;
        upc_addr_o  = st_q.addr;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{spc: SPC_ROM, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
    parameter int RAW    = 12,
    parameter int NMATCH = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              disp_valid_i,
    input logic [RAW-1:0]    disp_addr_i,
    input logic [NMATCH-1:0] match_en_i,
    input logic              uop_valid_o,
    input logic              uop_jmp,
    input logic              upc_space_o,
    input logic [RAW-1:0]    upc_addr_o
);
    // R1: first cycle after reset fetches read-only address 0
    a_r1_reset_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (upc_space_o == 1'b0 && upc_addr_o == '0));

    // R2: non-jump read-only word steps to the next address
    a_r2_rom_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upc_space_o == 1'b0 && uop_valid_o && !uop_jmp && !disp_valid_i)
        |=> (upc_space_o == 1'b0 && upc_addr_o == $past(upc_addr_o) + 1'b1));

    // R3: an entry request sets the next fetch
    a_r3_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        disp_valid_i |=> (upc_space_o == 1'b0 && upc_addr_o == $past(disp_addr_i)));

    // R4: a bubble is followed by a patch fetch
    a_r4_trap_to_patch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!uop_valid_o && !disp_valid_i) |=> (upc_space_o == 1'b1));

    // R6: patch fetches never trap
    a_r6_patch_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upc_space_o == 1'b1) |-> uop_valid_o);

    // R8: all enables low means no trap
    a_r8_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_en_i == '0 && upc_space_o == 1'b0) |-> uop_valid_o);
endmodule

bind ucode_seq ucode_seq_chk #(.RAW(RAW), .NMATCH(NMATCH)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .disp_valid_i (disp_valid_i),
    .disp_addr_i  (disp_addr_i),
    .match_en_i   (match_en_i),
    .uop_valid_o  (uop_valid_o),
    .uop_jmp      (uop_o[UW-1]),
    .upc_space_o  (upc_space_o),
    .upc_addr_o   (upc_addr_o)
);

// File: tb/ucode_seq_tb.sv
module ucode_seq_tb;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        disp_valid = 1'b0;
    logic [11:0] disp_addr = '0;
    logic [3:0]  match_en = 4'hF;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        uop_valid;
    logic [31:0] uop;
    logic        upc_space;
    logic [11:0] upc_addr;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] pimg [60];

    always #5 clk = ~clk;

    ucode_seq u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .disp_valid_i (disp_valid),
        .disp_addr_i  (disp_addr),
        .match_en_i   (match_en),
        .cfg_we_i     (cfg_we),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .uop_valid_o  (uop_valid),
        .uop_o        (uop),
        .upc_space_o  (upc_space),
        .upc_addr_o   (upc_addr)
    );

    // Patch words (format of R2)
    localparam logic [31:0] P0  = {1'b0, 1'b0, 12'h000, 18'h00100};
    localparam logic [31:0] P1  = {1'b1, 1'b0, 12'h023, 18'h00101};
    localparam logic [31:0] P5  = {1'b1, 1'b0, 12'h041, 18'h00105};
    localparam logic [31:0] P30 = {1'b1, 1'b0, 12'h061, 18'h0011E};
    localparam logic [31:0] P59 = {1'b0, 1'b0, 12'h000, 18'h0013B};

    // Row: {req[3:0], chk, dv, da[11:0], sp, ea[11:0], ev}
    localparam int NROW = 19;
    localparam logic [31:0] TBL [NROW] = '{
        {4'd3,  1'b0, 1'b1, 12'h01E, 1'b0, 12'h000, 1'b1}, // R3 start
        {4'd2,  1'b1, 1'b0, 12'h000, 1'b0, 12'h01E, 1'b1}, // R2
        {4'd2,  1'b1, 1'b0, 12'h000, 1'b0, 12'h01F, 1'b1}, // R2
        {4'd4,  1'b1, 1'b0, 12'h000, 1'b0, 12'h020, 1'b0}, // R4 bubble
        {4'd4,  1'b1, 1'b0, 12'h000, 1'b1, 12'h000, 1'b1}, // R4 patch entry
        {4'd7,  1'b1, 1'b0, 12'h000, 1'b1, 12'h001, 1'b1}, // R7 patch step
        {4'd7,  1'b1, 1'b0, 12'h000, 1'b0, 12'h023, 1'b1}, // R7 return
        {4'd3,  1'b1, 1'b1, 12'h03F, 1'b0, 12'h024, 1'b1}, // R3
        {4'd3,  1'b1, 1'b0, 12'h000, 1'b0, 12'h03F, 1'b1}, // R3
        {4'd5,  1'b1, 1'b0, 12'h000, 1'b0, 12'h040, 1'b0}, // R5 two hits
        {4'd5,  1'b1, 1'b0, 12'h000, 1'b1, 12'h005, 1'b1}, // R5 lowest wins
        {4'd7,  1'b1, 1'b1, 12'h05F, 1'b0, 12'h041, 1'b1}, // R7 return
        {4'd9,  1'b1, 1'b0, 12'h000, 1'b0, 12'h05F, 1'b1}, // R9
        {4'd9,  1'b1, 1'b0, 12'h000, 1'b0, 12'h060, 1'b1}, // R9 unarmed
        {4'd9,  1'b1, 1'b0, 12'h000, 1'b0, 12'h061, 1'b1}, // R9
        {4'd2,  1'b1, 1'b1, 12'h01F, 1'b0, 12'h062, 1'b1}, // R2
        {4'd2,  1'b1, 1'b0, 12'h000, 1'b0, 12'h01F, 1'b1}, // R2
        {4'd3,  1'b1, 1'b1, 12'h070, 1'b0, 12'h020, 1'b0}, // R3 over trap
        {4'd3,  1'b1, 1'b0, 12'h000, 1'b0, 12'h070, 1'b1}  // R3
    };

    function automatic string req_name(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10";
            default: return "R?";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic sp, input logic [11:0] ea,
                       input logic ev);
        logic [31:0] ew;
        if (!ev) ew = '0;
        else if (sp) ew = pimg[ea[5:0]];
        else ew = {20'h0, ea};
        n_chk++;
        if (upc_space !== sp || upc_addr !== ea || uop_valid !== ev || uop !== ew) begin
            n_fail++;
            $display("FAIL %s: got sp=%0b addr=%h v=%0b uop=%h, expected sp=%0b addr=%h v=%0b uop=%h",
                     req, upc_space, upc_addr, uop_valid, uop, sp, ea, ev, ew);
        end
    endtask

    task automatic cfg_patch(input int idx, input logic [31:0] w);
        cfg_we = 1'b1;
        cfg_addr = {1'b0, 6'(idx)};
        cfg_wdata = w;
        if (idx < 60) pimg[idx] = w;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic cfg_match(input int idx, input logic v, input logic [11:0] ra,
                             input logic [5:0] tg);
        cfg_we = 1'b1;
        cfg_addr = {1'b1, 4'b0, 2'(idx)};
        cfg_wdata = {13'b0, v, ra, tg};
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic disp(input logic [11:0] a);
        disp_valid = 1'b1;
        disp_addr = a;
        tick();
        disp_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        tick();
        tick();
        rst_ni = 1'b1;
        #1;
        for (int i = 0; i < 60; i++) pimg[i] = '0;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 60; i++) pimg[i] = '0;
        tick();
        do_reset();
        // R1 reset state: fetch from read-only address 0, then 1
        chk("R1", 1'b0, 12'h000, 1'b1);
        tick();
        chk("R1", 1'b0, 12'h001, 1'b1);

        cfg_patch(0, P0);
        cfg_patch(1, P1);
        cfg_patch(5, P5);
        cfg_patch(59, P59);
        cfg_match(0, 1'b1, 12'h020, 6'd0);
        cfg_match(1, 1'b1, 12'h040, 6'd5);
        cfg_match(2, 1'b1, 12'h040, 6'd59);
        cfg_match(3, 1'b1, 12'h060, 6'd30); // target unwritten: rejected

        for (int i = 0; i < NROW; i++) begin
            logic [31:0] row;
            row = TBL[i];
            if (row[27]) chk(req_name(int'(row[31:28])), row[13], row[12:1], row[0]);
            disp_valid = row[26];
            disp_addr = row[25:14];
            tick();
            disp_valid = 1'b0;
        end

        // R9: arming accepted once the target word exists
        cfg_patch(30, P30);
        cfg_match(3, 1'b1, 12'h060, 6'd30);
        disp(12'h05F);
        chk("R9", 1'b0, 12'h05F, 1'b1);
        tick();
        chk("R9", 1'b0, 12'h060, 1'b0);
        tick();
        chk("R4", 1'b1, 12'h01E, 1'b1);
        tick();
        chk("R7", 1'b0, 12'h061, 1'b1);

        // R8 mask register 1; R5 next priority; R7 wrap; R6 no trap in patch space
        cfg_match(3, 1'b1, 12'h001, 6'd30);
        match_en = 4'b1101;
        disp(12'h040);
        chk("R8", 1'b0, 12'h040, 1'b0);
        tick();
        chk("R8", 1'b1, 12'h03B, 1'b1);
        tick();
        chk("R7", 1'b1, 12'h000, 1'b1);
        tick();
        chk("R6", 1'b1, 12'h001, 1'b1);
        tick();
        chk("R7", 1'b0, 12'h023, 1'b1);

        // R8 all masked
        match_en = 4'b0000;
        disp(12'h020);
        chk("R8", 1'b0, 12'h020, 1'b1);
        tick();
        chk("R2", 1'b0, 12'h021, 1'b1);

        // R9 disarm by a write with the valid bit clear
        match_en = 4'b1111;
        cfg_match(0, 1'b0, 12'h020, 6'd0);
        disp(12'h020);
        chk("R9", 1'b0, 12'h020, 1'b1);

        // R10 out-of-range patch index never counts as written
        cfg_patch(60, 32'h8000_0ABC);
        cfg_match(2, 1'b1, 12'h050, 6'd60);
        disp(12'h04F);
        chk("R10", 1'b0, 12'h04F, 1'b1);
        tick();
        chk("R10", 1'b0, 12'h050, 1'b1);

        // R1 second reset clears arming and the written-word record
        do_reset();
        chk("R1", 1'b0, 12'h000, 1'b1);
        disp(12'h040);
        chk("R1", 1'b0, 12'h040, 1'b1);
        cfg_match(0, 1'b1, 12'h020, 6'd0);
        disp(12'h020);
        chk("R1", 1'b0, 12'h020, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule